// File: doc/BRIEF.md
# Privileged Control/Debug Register Access Unit

This unit carries out privileged moves between a general register and the processor's control and debug register files. It also carries out the clear-task-switched operation. One request is accepted per cycle. The unit decides whether the request is allowed, and then either commits the read or write or reports a single fault. It holds three control registers: the mode register (index 0), the fault-address register (index 2) and the table-base register (index 3). It also holds six debug slots: four breakpoint-address slots, one status slot and one debug-control slot.

Requests arrive on a valid/ready channel. `req_ready` is tied high, so the unit never applies back-pressure, and each cycle with `req_valid` high is one accepted request. The result appears one cycle after acceptance as plain status pins: a one-cycle `done` strobe, the read value, and at most one of the two fault pins. The fault pins are `fault_gp` (general protection) and `fault_ud` (undefined operation). No response is held back or retried. The caller must take the response in the cycle it is shown.

Top module: `privreg_access_unit`

## Requirements
- R1: When `req_cpl` is not zero, every operation, clear-task-switched included, raises `fault_gp` and leaves all registers unchanged.
- R2: Control index 0 selects the mode register, and indices 2 and 3 select the fault-address and table-base registers. A write to any of them is read back unchanged. Control index 1 and indices 4 to 7 raise `fault_ud`.
- R3: A control write to index 0 raises `fault_gp` and is dropped in either of two cases. The first is when bit 31 (paging) is set while bit 0 (protection enable) is clear. The second is when bit 29 (no-write-through) is set while bit 30 (cache disable) is clear.
- R4: Debug indices 0 to 5 select slots 0 to 5 directly. Indices 6 and 7 are aliases of slots 4 and 5.
- R5: While bit 13 (access lockout) of the debug-control slot is set, every debug read or write raises `fault_gp` and changes nothing. Control-register operations are not affected by the lockout.
- R6: A write to the status slot is stored with mask 0xFFFF0FF0 forced to ones. A write to the debug-control slot is stored with mask 0x0000DC00 forced to zeros.
- R7: Clear-task-switched clears only bit 3 of the mode register.
- R8: Faults are checked in this order: privilege, then operation or index validity, then lockout, then the value check. `done` pulses for exactly one cycle, one cycle after each accepted request. At most one fault pin is high, and only together with `done`.
- R9: After reset, all registers read zero, except the status slot, which reads 0xFFFF0FF0.
- R10: The operation codes are 0 = control read, 1 = control write, 2 = debug read, 3 = debug write and 4 = clear-task-switched. Codes 5 to 7 raise `fault_ud`. `rd_data` carries the register value for a read that does not fault, and zero in every other case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; the unit accepts a request every cycle |
| req_op | input | 3 | Operation code |
| req_idx | input | 3 | Register index |
| req_wdata | input | 32 | Value to write |
| req_cpl | input | 2 | Current privilege level |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 32 | Read result |
| fault_gp | output | 1 | General-protection fault pulse |
| fault_ud | output | 1 | Undefined-operation fault pulse |

## Verification
Two checks can trigger on the same request. The privilege check can coincide with the mode-register value check, and the lockout can coincide with a write aimed at the debug-control slot, which is the one write that could clear the lockout. The bench provokes these overlaps with directed requests: an illegal mode value sent at a nonzero privilege, an invalid control index sent at a nonzero privilege, and a debug-control write sent while the lockout is set. It then reads the registers back to confirm the lower-priority effect did not happen. Random requests from a fixed seed mix privilege levels, indices and values, and each response is compared with a model kept in the bench.

// File: rtl/pra_pkg.sv
package pra_pkg;
  localparam logic [2:0] OP_CR_RD  = 3'd0;
  localparam logic [2:0] OP_CR_WR  = 3'd1;
  localparam logic [2:0] OP_DR_RD  = 3'd2;
  localparam logic [2:0] OP_DR_WR  = 3'd3;
  localparam logic [2:0] OP_CLR_TS = 3'd4;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2
  } pra_fault_e;
endpackage

// File: rtl/pra_gate.sv
module pra_gate
  import pra_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int CPL_W     = 2,
  parameter int CR_SLOTS  = 3,
  parameter int DBG_SLOTS = 6,
  localparam int CSEL_W   = $clog2(CR_SLOTS),
  localparam int DSEL_W   = $clog2(DBG_SLOTS)
) (
  input  logic [2:0]       op,
  input  logic [IDX_W-1:0] idx,
  input  logic [CPL_W-1:0] cpl,
  // {paging, no-write-through, cache-disable, protection-enable} of the write value
  input  logic [3:0]       mode_key,
  input  logic             lockout,
  output pra_fault_e       fault,
  output logic [CSEL_W-1:0] cr_sel,
  output logic [DSEL_W-1:0] dr_sel
);
  logic is_cr, is_dr, known, cr_idx_ok, mode_bad;

  always_comb begin
    is_cr     = (op == OP_CR_RD) || (op == OP_CR_WR);
    is_dr     = (op == OP_DR_RD) || (op == OP_DR_WR);
    known     = is_cr || is_dr || (op == OP_CLR_TS);
    cr_idx_ok = (idx == '0) || ((idx >= IDX_W'(2)) && (idx <= IDX_W'(CR_SLOTS)));
    cr_sel    = (idx == '0) ? '0 : CSEL_W'(idx - IDX_W'(1));
    // upper indices fold back by two onto the status and control slots
    dr_sel    = (idx >= IDX_W'(DBG_SLOTS)) ? DSEL_W'(idx - IDX_W'(2)) : DSEL_W'(idx);
    mode_bad  = (mode_key[3] && !mode_key[0]) || (mode_key[2] && !mode_key[1]);

    if (cpl != '0)                                   fault = FLT_GP;
    else if (!known)                                 fault = FLT_UD;
    else if (is_cr && !cr_idx_ok)                    fault = FLT_UD;
    else if (is_dr && lockout)                       fault = FLT_GP;
    else if ((op == OP_CR_WR) && (idx == '0) && mode_bad) fault = FLT_GP;
    else                                             fault = FLT_NONE;
  end
endmodule

// File: rtl/pra_ctrl_file.sv
module pra_ctrl_file #(
  parameter int DATA_W   = 32,
  parameter int CR_SLOTS = 3,
  parameter int TS_BIT   = 3,
  parameter int PE_BIT   = 0,
  parameter int NW_BIT   = 29,
  parameter int CD_BIT   = 30,
  parameter int PG_BIT   = 31,
  localparam int CSEL_W  = $clog2(CR_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSEL_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_ts,
  input  logic [CSEL_W-1:0] rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] cr_vec [CR_SLOTS];

  for (genvar g = 0; g < CR_SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    if (g == 0) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     slot_q <= '0;
        else if (wr_en && (wr_sel == CSEL_W'(g)))       slot_q <= wr_data;
        else if (clr_ts)                                slot_q[TS_BIT] <= 1'b0;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     slot_q <= '0;
        else if (wr_en && (wr_sel == CSEL_W'(g)))       slot_q <= wr_data;
      end
    end
    assign cr_vec[g] = slot_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < CR_SLOTS; i++)
      if (rd_sel == CSEL_W'(i)) rd_data = cr_vec[i];
  end

  localparam logic [DATA_W-1:0] TS_MASK = DATA_W'(1) << TS_BIT;

  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cr_vec[0][PG_BIT] && !cr_vec[0][PE_BIT]) && !(cr_vec[0][NW_BIT] && !cr_vec[0][CD_BIT]));

  assert_clrts_only_ts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ts && !wr_en) |=> (!cr_vec[0][TS_BIT] &&
      ((cr_vec[0] | TS_MASK) == ($past(cr_vec[0]) | TS_MASK))));
endmodule

// File: rtl/pra_debug_file.sv
module pra_debug_file #(
  parameter int DATA_W    = 32,
  parameter int BP_SLOTS  = 4,
  parameter int GD_BIT    = 13,
  parameter logic [DATA_W-1:0] STAT_ONES  = 32'hFFFF0FF0,
  parameter logic [DATA_W-1:0] CTL_ZEROS  = 32'h0000DC00,
  localparam int DBG_SLOTS = BP_SLOTS + 2,
  localparam int STAT_SLOT = BP_SLOTS,
  localparam int CTL_SLOT  = BP_SLOTS + 1,
  localparam int DSEL_W    = $clog2(DBG_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DSEL_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DSEL_W-1:0] rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              lockout
);
  logic [DATA_W-1:0] dr_vec [DBG_SLOTS];

  for (genvar g = 0; g < DBG_SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic [DATA_W-1:0] shaped;
    logic [DATA_W-1:0] rst_val;
    if (g == STAT_SLOT) begin : g_stat
      assign shaped  = wr_data | STAT_ONES;
      assign rst_val = STAT_ONES;
    end else if (g == CTL_SLOT) begin : g_ctl
      assign shaped  = wr_data & ~CTL_ZEROS;
      assign rst_val = '0;
    end else begin : g_bp
      assign shaped  = wr_data;
      assign rst_val = '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q <= rst_val;
      else if (wr_en && (wr_sel == DSEL_W'(g)))    slot_q <= shaped;
    end
    assign dr_vec[g] = slot_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DBG_SLOTS; i++)
      if (rd_sel == DSEL_W'(i)) rd_data = dr_vec[i];
  end

  assign lockout = dr_vec[CTL_SLOT][GD_BIT];

  assert_stat_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_vec[STAT_SLOT] & STAT_ONES) == STAT_ONES);

  assert_ctl_zeros_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_vec[CTL_SLOT] & CTL_ZEROS) == '0);
endmodule

// File: rtl/privreg_access_unit.sv
module privreg_access_unit
  import pra_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3,
  parameter int CPL_W    = 2,
  parameter int BP_SLOTS = 4,
  parameter int TS_BIT   = 3,
  parameter int PE_BIT   = 0,
  parameter int NW_BIT   = 29,
  parameter int CD_BIT   = 30,
  parameter int PG_BIT   = 31,
  parameter int GD_BIT   = 13,
  parameter logic [DATA_W-1:0] STAT_ONES = 32'hFFFF0FF0,
  parameter logic [DATA_W-1:0] CTL_ZEROS = 32'h0000DC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CPL_W-1:0]  req_cpl,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              fault_gp,
  output logic              fault_ud
);
  localparam int CR_SLOTS  = 3;
  localparam int DBG_SLOTS = BP_SLOTS + 2;
  localparam int CSEL_W    = $clog2(CR_SLOTS);
  localparam int DSEL_W    = $clog2(DBG_SLOTS);

  pra_fault_e        fault;
  logic [CSEL_W-1:0] cr_sel;
  logic [DSEL_W-1:0] dr_sel;
  logic [DATA_W-1:0] cr_rd, dr_rd;
  logic              lockout, commit;
  logic [3:0]        mode_key;

  assign req_ready = 1'b1;
  assign mode_key  = {req_wdata[PG_BIT], req_wdata[NW_BIT], req_wdata[CD_BIT], req_wdata[PE_BIT]};
  assign commit    = req_valid && (fault == FLT_NONE);

  pra_gate #(
    .IDX_W(IDX_W), .CPL_W(CPL_W), .CR_SLOTS(CR_SLOTS), .DBG_SLOTS(DBG_SLOTS)
  ) u_gate (
    .op(req_op), .idx(req_idx), .cpl(req_cpl), .mode_key(mode_key),
    .lockout(lockout), .fault(fault), .cr_sel(cr_sel), .dr_sel(dr_sel)
  );

  pra_ctrl_file #(
    .DATA_W(DATA_W), .CR_SLOTS(CR_SLOTS), .TS_BIT(TS_BIT), .PE_BIT(PE_BIT),
    .NW_BIT(NW_BIT), .CD_BIT(CD_BIT), .PG_BIT(PG_BIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit && (req_op == OP_CR_WR)), .wr_sel(cr_sel), .wr_data(req_wdata),
    .clr_ts(commit && (req_op == OP_CLR_TS)),
    .rd_sel(cr_sel), .rd_data(cr_rd)
  );

  pra_debug_file #(
    .DATA_W(DATA_W), .BP_SLOTS(BP_SLOTS), .GD_BIT(GD_BIT),
    .STAT_ONES(STAT_ONES), .CTL_ZEROS(CTL_ZEROS)
  ) u_dbg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit && (req_op == OP_DR_WR)), .wr_sel(dr_sel), .wr_data(req_wdata),
    .rd_sel(dr_sel), .rd_data(dr_rd), .lockout(lockout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      fault_gp <= 1'b0;
      fault_ud <= 1'b0;
      rd_data  <= '0;
    end else begin
      done     <= req_valid;
      fault_gp <= req_valid && (fault == FLT_GP);
      fault_ud <= req_valid && (fault == FLT_UD);
      if (commit && (req_op == OP_CR_RD))      rd_data <= cr_rd;
      else if (commit && (req_op == OP_DR_RD)) rd_data <= dr_rd;
      else                                     rd_data <= '0;
    end
  end

  assert_one_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_gp, fault_ud}));

  assert_fault_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_gp || fault_ud) |-> done);

  assert_priv_gp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_cpl != '0)) |=> (fault_gp && !fault_ud && (rd_data == '0)));

  assert_lockout_gp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_cpl == '0) && lockout &&
     ((req_op == OP_DR_RD) || (req_op == OP_DR_WR))) |=> fault_gp);
endmodule

// File: tb/test_privreg_access_unit.sv
`timescale 1ns/1ps
module test_privreg_access_unit;
  localparam logic [31:0] STAT_ONES = 32'hFFFF0FF0;
  localparam logic [31:0] CTL_ZEROS = 32'h0000DC00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0, req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0] req_cpl = '0;
  logic done, fault_gp, fault_ud;
  logic [31:0] rd_data;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] m_cr [3];
  logic [31:0] m_dr [6];

  always #4 clk = ~clk;

  privreg_access_unit i_privreg_access_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_idx(req_idx), .req_wdata(req_wdata), .req_cpl(req_cpl),
    .done(done), .rd_data(rd_data), .fault_gp(fault_gp), .fault_ud(fault_ud)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) m_cr[i] = '0;
    for (int i = 0; i < 6; i++) m_dr[i] = '0;
    m_dr[4] = STAT_ONES;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic do_req(input logic [2:0] op, input logic [2:0] idx,
                        input logic [31:0] wd, input logic [1:0] cpl, input string tag);
    logic eg, eu, is_cr, is_dr, cr_ok;
    logic [31:0] er;
    int cs, ds;
    string t;
    eg = 0; eu = 0; er = '0;
    is_cr = (op == 3'd0) || (op == 3'd1);
    is_dr = (op == 3'd2) || (op == 3'd3);
    cr_ok = (idx == 3'd0) || (idx == 3'd2) || (idx == 3'd3);
    cs = (idx == 3'd0) ? 0 : (idx == 3'd2) ? 1 : 2;
    ds = (idx >= 3'd6) ? int'(idx) - 2 : int'(idx);
    if (cpl != 2'd0)                  eg = 1;
    else if (op > 3'd4)               eu = 1;
    else if (is_cr && !cr_ok)         eu = 1;
    else if (is_dr && m_dr[5][13])    eg = 1;
    else if (op == 3'd1 && idx == 3'd0 &&
             ((wd[31] && !wd[0]) || (wd[29] && !wd[30]))) eg = 1;
    if (tag != "") t = tag;
    else if (cpl != 2'd0) t = "R1";
    else if (op > 3'd4) t = "R10";
    else if (is_cr) t = (eg ? "R3" : "R2");
    else if (is_dr) t = (eg ? "R5" : (ds >= 4 ? "R6" : "R4"));
    else t = "R7";
    if (!eg && !eu) begin
      case (op)
        3'd0: er = m_cr[cs];
        3'd1: m_cr[cs] = wd;
        3'd2: er = m_dr[ds];
        3'd3: m_dr[ds] = (ds == 4) ? (wd | STAT_ONES) : (ds == 5) ? (wd & ~CTL_ZEROS) : wd;
        default: m_cr[0][3] = 1'b0;
      endcase
    end
    req_op = op; req_idx = idx; req_wdata = wd; req_cpl = cpl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({t, " done"}, {31'd0, done}, 32'd1);
    chk({t, " gp"}, {31'd0, fault_gp}, {31'd0, eg});
    chk({t, " ud"}, {31'd0, fault_ud}, {31'd0, eu});
    chk({t, " rd_data"}, rd_data, er);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R8 idle done", {31'd0, done}, 32'd0);
    chk("R8 idle faults", {30'd0, fault_gp, fault_ud}, 32'd0);
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    model_reset();
    apply_reset();
    chk("R10 ready", {31'd0, req_ready}, 32'd1);
    // R9: reset values
    do_req(3'd0, 3'd0, '0, 2'd0, "R9 cr0");
    do_req(3'd0, 3'd2, '0, 2'd0, "R9 cr2");
    do_req(3'd0, 3'd3, '0, 2'd0, "R9 cr3");
    for (int i = 0; i < 8; i++) do_req(3'd2, 3'(i), '0, 2'd0, "R9 dbg");
    // R2: control index map
    do_req(3'd1, 3'd2, 32'hDEAD_BEEF, 2'd0, "R2");
    do_req(3'd1, 3'd3, 32'h1234_5000, 2'd0, "R2");
    do_req(3'd0, 3'd2, '0, 2'd0, "R2 readback cr2");
    do_req(3'd0, 3'd3, '0, 2'd0, "R2 readback cr3");
    do_req(3'd1, 3'd1, 32'hFFFF_FFFF, 2'd0, "R2 idx1");
    for (int i = 4; i < 8; i++) do_req(3'd0, 3'(i), '0, 2'd0, "R2 bad idx");
    // R3: mode register value check
    do_req(3'd1, 3'd0, 32'h8000_0000, 2'd0, "R3 pg no pe");
    do_req(3'd1, 3'd0, 32'h2000_0000, 2'd0, "R3 nw no cd");
    do_req(3'd0, 3'd0, '0, 2'd0, "R3 unchanged");
    do_req(3'd1, 3'd0, 32'hE000_000B, 2'd0, "R3 legal");
    do_req(3'd0, 3'd0, '0, 2'd0, "R3 readback");
    // R1 and R8 overlaps: privilege wins over value, index and clear-TS
    do_req(3'd4, 3'd0, '0, 2'd3, "R1 clts");
    do_req(3'd1, 3'd0, 32'h8000_0000, 2'd1, "R8 priv over value");
    do_req(3'd0, 3'd5, '0, 2'd2, "R8 priv over index");
    do_req(3'd0, 3'd0, '0, 2'd0, "R1 ts kept");
    // R7: clear-TS
    do_req(3'd4, 3'd0, '0, 2'd0, "R7");
    do_req(3'd0, 3'd0, '0, 2'd0, "R7 readback");
    idle_check();
    // R4 and R6: aliasing and reserved masks
    do_req(3'd3, 3'd6, 32'h0000_0000, 2'd0, "R6 status ones");
    do_req(3'd2, 3'd4, '0, 2'd0, "R4 alias 6->4");
    do_req(3'd3, 3'd7, 32'hFFFF_DFFF, 2'd0, "R6 ctl zeros");
    do_req(3'd2, 3'd5, '0, 2'd0, "R4 alias 7->5");
    do_req(3'd3, 3'd2, 32'h0BAD_F00D, 2'd0, "R4");
    do_req(3'd2, 3'd2, '0, 2'd0, "R4 readback");
    // R10: unused operation codes
    for (int i = 5; i < 8; i++) do_req(3'(i), 3'd0, '0, 2'd0, "R10");
    // R5: lockout, including a write that would clear it
    do_req(3'd3, 3'd5, 32'h0000_2000, 2'd0, "R5 set");
    do_req(3'd2, 3'd0, '0, 2'd0, "R5 read locked");
    do_req(3'd3, 3'd7, 32'h0000_0000, 2'd0, "R5 clear attempt");
    do_req(3'd0, 3'd2, '0, 2'd0, "R5 cr unaffected");
    do_req(3'd0, 3'd1, '0, 2'd0, "R8 index over lockout");
    do_req(3'd2, 3'd4, '0, 2'd1, "R8 priv over lockout");
    apply_reset();
    do_req(3'd2, 3'd5, '0, 2'd0, "R9 lockout cleared");
    // random traffic
    for (int n = 0; n < 800; n++) begin
      logic [2:0] op, idx;
      logic [31:0] wd;
      logic [1:0] cpl;
      op  = ($urandom % 6 == 5) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      idx = 3'($urandom % 8);
      wd  = $urandom;
      cpl = ($urandom % 8 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
      if (op == 3'd3 && (idx == 3'd5 || idx == 3'd7)) wd[13] = 1'b0;
      do_req(op, idx, wd, cpl, "");
      if ($urandom % 16 == 0) idle_check();
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule